// File: doc/BRIEF.md
# Accumulator-Register Execute ALU with Status Flags

This block is the execute-stage arithmetic unit of a small 8-bit accumulator machine. Each cycle in which `valid_i` is high, it takes the accumulator value, one register operand, the current Carry, Digit Carry and Zero flags, a bit index and a destination-select bit. One clock edge later it presents the result, a write strobe for the accumulator or for the register, the updated flags and a skip request. The surrounding core writes the result where the strobe points, takes the flags as its new status, and on a skip request discards the following instruction. The ALU itself does not sequence anything.

Each instruction class updates its own subset of flags. A flag outside that subset is passed through unchanged from its input, so the flag outputs always carry the complete new status. Subtraction takes the accumulator from the register operand, and Carry set means that no borrow occurred. Two decimal-adjust operations convert the accumulator to packed BCD after a binary addition or subtraction.

Top module: `alu8_exec`

## Requirements
- R1: `op_i` encodes ADD=0, ADC=1, SUB=2, SBC=3, AND=4, IOR=5, XOR=6, COM=7, INC=8, INCSZ=9, DEC=10, DECSZ=11, RLC=12, BSET=13, BCLR=14, BTSC=15, BTSS=16, DADD=17, DSUB=18. For codes 0..12, `dest_r_i`=1 raises `wr_reg_o` and `dest_r_i`=0 raises `wr_acc_o`. Codes 19..31 write nothing, request no skip and leave all flags unchanged. The two write strobes are never high together.
- R2: All outputs appear one clock edge after the input cycle with `valid_i` high, together with `valid_o`=1. In a cycle after `valid_i` was low, `valid_o`, both write strobes and `skip_o` are 0.
- R3: ADD gives R+ACC and ADC gives R+ACC+C. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is set when the 8-bit result is 0.
- R4: SUB gives R-ACC and SBC gives R-ACC-(1-C). C=1 means no borrow (R >= ACC plus the borrow-in). DC=1 means no borrow out of the low nibble. Z is set on a zero result.
- R5: AND, IOR, XOR (with ACC) and COM (the inverse of R) update only Z.
- R6: INC and DEC give R+1 and R-1 modulo 256 and update only Z. INCSZ and DECSZ produce the same results, raise `skip_o` when the result is 0, and leave all flags unchanged.
- R7: RLC returns {R[6:0], C} and sets C to R[7]. DC and Z are unchanged.
- R8: BSET and BCLR set or clear bit `bsel_i` (0 = LSB) of R, always write to R whatever `dest_r_i` is, and change no flags.
- R9: BTSC raises `skip_o` when bit `bsel_i` of R is 0, and BTSS raises it when that bit is 1. Neither writes a result or changes a flag.
- R10: DADD adds 6 to ACC when ACC[3:0] > 9 or DC=1, then adds 0x60 when C=1 or ACC > 0x99. C becomes 1 exactly when the 0x60 correction was applied. The result is written to ACC, and DC and Z are unchanged.
- R11: DSUB subtracts 6 from ACC when DC=0 and subtracts 0x60 when C=0. The result is written to ACC and all flags are unchanged.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opr_i | input | 8 | Register operand R |
| bsel_i | input | 3 | Bit index for bit operations |
| dest_r_i | input | 1 | 1 = result to R, 0 = result to ACC |
| c_i | input | 1 | Current Carry flag |
| dc_i | input | 1 | Current Digit Carry flag |
| z_i | input | 1 | Current Zero flag |
| valid_o | output | 1 | Results below are valid |
| res_o | output | 8 | Result value |
| wr_acc_o | output | 1 | Write result to ACC |
| wr_reg_o | output | 1 | Write result to R |
| c_o | output | 1 | New Carry flag |
| dc_o | output | 1 | New Digit Carry flag |
| z_o | output | 1 | New Zero flag |
| skip_o | output | 1 | Skip the next instruction |

## Verification
Every result, strobe and flag goes through a single register stage, so the outputs for an operation are due exactly one rising edge after it is presented. The bench drives each operation on a falling edge, waits for the next rising edge, and compares all outputs at the following falling edge, before it drives the next operation. The strobe-clearing rule is checked in an idle cycle after `valid_i` drops, one edge later. The reset state is sampled on a falling edge while reset is still held.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,  OP_ADC   = 5'd1,  OP_SUB   = 5'd2,  OP_SBC   = 5'd3,
    OP_AND   = 5'd4,  OP_IOR   = 5'd5,  OP_XOR   = 5'd6,  OP_COM   = 5'd7,
    OP_INC   = 5'd8,  OP_INCSZ = 5'd9,  OP_DEC   = 5'd10, OP_DECSZ = 5'd11,
    OP_RLC   = 5'd12, OP_BSET  = 5'd13, OP_BCLR  = 5'd14, OP_BTSC  = 5'd15,
    OP_BTSS  = 5'd16, OP_DADD  = 5'd17, OP_DSUB  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opr_i,
  input  logic              c_i,
  input  logic              dc_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              dc_o
);
  localparam logic [DATA_W-1:0] LO_FIX = DATA_W'(6);
  localparam logic [DATA_W-1:0] HI_FIX = DATA_W'(6) << NIB_W;
  localparam logic [DATA_W-1:0] BCD_MAX = DATA_W'(8'h99);

  logic              is_sub;
  logic              cin;
  logic [DATA_W-1:0] b_opd;
  logic [NIB_W:0]    lo_sum;
  logic [DATA_W:0]   full_sum;
  logic              lo_adj;
  logic              hi_adj;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_SBC);
    b_opd    = is_sub ? ~acc_i : acc_i;
    unique case (op)
      OP_ADC, OP_SBC: cin = c_i;
      OP_SUB:         cin = 1'b1;
      default:        cin = 1'b0;
    endcase
    lo_sum   = {1'b0, opr_i[NIB_W-1:0]} + {1'b0, b_opd[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    full_sum = {1'b0, opr_i} + {1'b0, b_opd} + {{DATA_W{1'b0}}, cin};
    lo_adj   = 1'b0;
    hi_adj   = 1'b0;
    res_o    = full_sum[DATA_W-1:0];
    c_o      = full_sum[DATA_W];
    dc_o     = lo_sum[NIB_W];
    if (op == OP_DADD) begin
      lo_adj = dc_i || (acc_i[NIB_W-1:0] > NIB_W'(9));
      hi_adj = c_i || (acc_i > BCD_MAX);
      res_o  = acc_i + (lo_adj ? LO_FIX : '0) + (hi_adj ? HI_FIX : '0);
      c_o    = hi_adj;
      dc_o   = dc_i;
    end else if (op == OP_DSUB) begin
      lo_adj = !dc_i;
      hi_adj = !c_i;
      res_o  = acc_i - (lo_adj ? LO_FIX : '0) - (hi_adj ? HI_FIX : '0);
      c_o    = c_i;
      dc_o   = dc_i;
    end
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opr_i,
  input  logic [BIT_W-1:0]  bsel_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;

  always_comb begin
    mask  = DATA_W'(1) << bsel_i;
    bit_o = opr_i[bsel_i];
    c_o   = c_i;
    unique case (op)
      OP_AND:            res_o = acc_i & opr_i;
      OP_IOR:            res_o = acc_i | opr_i;
      OP_XOR:            res_o = acc_i ^ opr_i;
      OP_COM:            res_o = ~opr_i;
      OP_INC, OP_INCSZ:  res_o = opr_i + DATA_W'(1);
      OP_DEC, OP_DECSZ:  res_o = opr_i - DATA_W'(1);
      OP_RLC: begin
        res_o = {opr_i[DATA_W-2:0], c_i};
        c_o   = opr_i[DATA_W-1];
      end
      OP_BSET:           res_o = opr_i | mask;
      OP_BCLR:           res_o = opr_i & ~mask;
      default:           res_o = opr_i;
    endcase
  end
endmodule

// File: rtl/alu8_exec.sv
module alu8_exec
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opr_i,
  input  logic [BIT_W-1:0]  bsel_i,
  input  logic              dest_r_i,
  input  logic              c_i,
  input  logic              dc_i,
  input  logic              z_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_acc_o,
  output logic              wr_reg_o,
  output logic              c_o,
  output logic              dc_o,
  output logic              z_o,
  output logic              skip_o
);
  alu_op_e           op;
  logic [DATA_W-1:0] as_res, bo_res, res_n;
  logic              as_c, as_dc, bo_c, bo_bit;
  logic              c_n, dc_n, z_n, wa_n, wr_n, sk_n, res_zero;

  logic              valid_q, wa_q, wr_q, sk_q, c_q, dc_q, z_q;
  logic [DATA_W-1:0] res_q;

  assign op = alu_op_e'(op_i);

  alu8_addsub u_addsub (
    .op(op), .acc_i(acc_i), .opr_i(opr_i), .c_i(c_i), .dc_i(dc_i),
    .res_o(as_res), .c_o(as_c), .dc_o(as_dc)
  );

  alu8_bitops u_bitops (
    .op(op), .acc_i(acc_i), .opr_i(opr_i), .bsel_i(bsel_i), .c_i(c_i),
    .res_o(bo_res), .c_o(bo_c), .bit_o(bo_bit)
  );

  // next-state
  always_comb begin
    c_n  = c_i;
    dc_n = dc_i;
    z_n  = z_i;
    wa_n = 1'b0;
    wr_n = 1'b0;
    sk_n = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_DADD, OP_DSUB: res_n = as_res;
      default:                                          res_n = bo_res;
    endcase
    res_zero = (res_n == '0);
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        c_n = as_c; dc_n = as_dc; z_n = res_zero;
        wa_n = !dest_r_i; wr_n = dest_r_i;
      end
      OP_AND, OP_IOR, OP_XOR, OP_COM, OP_INC, OP_DEC: begin
        z_n = res_zero;
        wa_n = !dest_r_i; wr_n = dest_r_i;
      end
      OP_INCSZ, OP_DECSZ: begin
        sk_n = res_zero;
        wa_n = !dest_r_i; wr_n = dest_r_i;
      end
      OP_RLC: begin
        c_n = bo_c;
        wa_n = !dest_r_i; wr_n = dest_r_i;
      end
      OP_BSET, OP_BCLR: wr_n = 1'b1;
      OP_BTSC:          sk_n = !bo_bit;
      OP_BTSS:          sk_n = bo_bit;
      OP_DADD: begin
        c_n = as_c;
        wa_n = 1'b1;
      end
      OP_DSUB:          wa_n = 1'b1;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wa_q    <= 1'b0;
      wr_q    <= 1'b0;
      sk_q    <= 1'b0;
      res_q   <= '0;
      c_q     <= 1'b0;
      dc_q    <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      valid_q <= valid_i;
      wa_q    <= valid_i & wa_n;
      wr_q    <= valid_i & wr_n;
      sk_q    <= valid_i & sk_n;
      if (valid_i) begin
        res_q <= res_n;
        c_q   <= c_n;
        dc_q  <= dc_n;
        z_q   <= z_n;
      end
    end
  end

  assign valid_o  = valid_q;
  assign res_o    = res_q;
  assign wr_acc_o = wa_q;
  assign wr_reg_o = wr_q;
  assign c_o      = c_q;
  assign dc_o     = dc_q;
  assign z_o      = z_q;
  assign skip_o   = sk_q;

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !(wa_q && wr_q)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (!wa_q && !wr_q && !sk_q)); // R2

  AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ($past(op_i) >= 5'd4) && ($past(op_i) <= 5'd7))
      |-> (c_q == $past(c_i) && dc_q == $past(dc_i))); // R5

  AST_SKIPZ_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ($past(op_i) == 5'd9 || $past(op_i) == 5'd11))
      |-> (c_q == $past(c_i) && dc_q == $past(dc_i) && z_q == $past(z_i))); // R6

  AST_BITWR_TO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ($past(op_i) == 5'd13 || $past(op_i) == 5'd14))
      |-> (wr_q && !wa_q)); // R8

  AST_BTEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && ($past(op_i) == 5'd15 || $past(op_i) == 5'd16))
      |-> (!wr_q && !wa_q)); // R9

  AST_DSUB_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(op_i) == 5'd18) |-> (c_q == $past(c_i) && wa_q)); // R11
endmodule

// File: tb/sim_alu8_exec.sv
module sim_alu8_exec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid_i;
  logic [4:0] op_i;
  logic [7:0] acc_i, opr_i;
  logic [2:0] bsel_i;
  logic       dest_r_i, c_i, dc_i, z_i;
  logic       valid_o, wr_acc_o, wr_reg_o, c_o, dc_o, z_o, skip_o;
  logic [7:0] res_o;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  alu8_exec u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .acc_i(acc_i),
    .opr_i(opr_i), .bsel_i(bsel_i), .dest_r_i(dest_r_i), .c_i(c_i), .dc_i(dc_i),
    .z_i(z_i), .valid_o(valid_o), .res_o(res_o), .wr_acc_o(wr_acc_o),
    .wr_reg_o(wr_reg_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o), .skip_o(skip_o)
  );

  typedef struct {
    int res; int wa; int wr; int c; int dc; int z; int sk;
  } exp_t;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int op);
    case (op)
      0, 1:          return "R3";
      2, 3:          return "R4";
      4, 5, 6, 7:    return "R5";
      8, 9, 10, 11:  return "R6";
      12:            return "R7";
      13, 14:        return "R8";
      15, 16:        return "R9";
      17:            return "R10";
      18:            return "R11";
      default:       return "R1";
    endcase
  endfunction

  function automatic exp_t model(int op, int a, int r, int b, int d, int c, int dc, int z);
    exp_t e;
    int v, bw;
    logic hi;
    e.res = r; e.wa = 0; e.wr = 0; e.c = c; e.dc = dc; e.z = z; e.sk = 0;
    if (op <= 12) begin e.wa = (d == 0); e.wr = (d == 1); end
    case (op)
      0, 1: begin
        v = r + a + ((op == 1) ? c : 0);
        e.res = v & 255; e.c = (v > 255);
        e.dc = (((r & 15) + (a & 15) + ((op == 1) ? c : 0)) > 15);
        e.z = (e.res == 0);
      end
      2, 3: begin
        bw = (op == 3) ? 1 - c : 0;
        e.res = (r - a - bw) & 255; e.c = (r >= a + bw);
        e.dc = ((r & 15) >= (a & 15) + bw); e.z = (e.res == 0);
      end
      4: begin e.res = a & r;   e.z = (e.res == 0); end
      5: begin e.res = a | r;   e.z = (e.res == 0); end
      6: begin e.res = a ^ r;   e.z = (e.res == 0); end
      7: begin e.res = 255 - r; e.z = (e.res == 0); end
      8: begin e.res = (r + 1) & 255; e.z = (e.res == 0); end
      10: begin e.res = (r + 255) & 255; e.z = (e.res == 0); end
      9: begin e.res = (r + 1) & 255; e.sk = (e.res == 0); end
      11: begin e.res = (r + 255) & 255; e.sk = (e.res == 0); end
      12: begin e.res = ((r * 2) + c) & 255; e.c = r / 128; end
      13: begin e.res = r | (1 << b); e.wr = 1; end
      14: begin e.res = r & (255 - (1 << b)); e.wr = 1; end
      15: e.sk = (((r >> b) & 1) == 0);
      16: e.sk = (((r >> b) & 1) == 1);
      17: begin
        v = a;
        if ((a & 15) > 9 || dc == 1) v = v + 6;
        hi = (c == 1) || (a > 153);
        if (hi) v = v + 96;
        e.res = v & 255; e.c = hi; e.wa = 1;
      end
      18: begin
        v = a;
        if (dc == 0) v = v - 6;
        if (c == 0) v = v - 96;
        e.res = v & 255; e.wa = 1;
      end
      default: ;
    endcase
    return e;
  endfunction

  // drive on a falling edge, check at the falling edge after the next rising edge
  task automatic run(int op, int a, int r, int b, int d, int c, int dc, int z);
    exp_t e;
    string rq;
    e = model(op, a, r, b, d, c, dc, z);
    rq = req_of(op);
    valid_i = 1'b1; op_i = 5'(op); acc_i = 8'(a); opr_i = 8'(r);
    bsel_i = 3'(b); dest_r_i = d[0]; c_i = c[0]; dc_i = dc[0]; z_i = z[0];
    @(posedge clk);
    @(negedge clk);
    chk("R2", "valid", int'(valid_o), 1);
    chk(rq, "wr_acc", int'(wr_acc_o), e.wa);
    chk(rq, "wr_reg", int'(wr_reg_o), e.wr);
    chk(rq, "skip", int'(skip_o), e.sk);
    chk(rq, "C", int'(c_o), e.c);
    chk(rq, "DC", int'(dc_o), e.dc);
    chk(rq, "Z", int'(z_o), e.z);
    if (e.wa != 0 || e.wr != 0) chk(rq, "res", int'(res_o), e.res);
  endtask

  initial begin
    int seed;
    rst_n = 1'b0; valid_i = 1'b0; op_i = '0; acc_i = '0; opr_i = '0;
    bsel_i = '0; dest_r_i = 1'b0; c_i = 1'b0; dc_i = 1'b0; z_i = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset outputs",
        int'({valid_o, res_o, wr_acc_o, wr_reg_o, c_o, dc_o, z_o, skip_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    run(0, 8'h01, 8'h99, 0, 0, 0, 0, 0);    // R3 plain binary add
    run(0, 8'h01, 8'hFF, 0, 1, 0, 0, 0);    // R3 wrap to zero, carry out
    run(1, 8'h0F, 8'h00, 0, 0, 1, 0, 0);    // R3 digit carry via carry-in
    run(17, 8'h9A, 0, 0, 0, 0, 0, 0);       // R10 0x9A -> 0x00, C=1
    run(17, 8'h61, 0, 0, 0, 0, 1, 0);       // R10 0x61 with DC -> 0x67
    run(2, 8'h15, 8'h42, 0, 0, 0, 0, 0);    // R4 R-ACC, low borrow
    run(18, 8'h2D, 0, 0, 0, 1, 0, 0);       // R11 0x2D -> 0x27
    run(2, 8'h43, 8'h42, 0, 0, 1, 1, 0);    // R4 borrow, C=0
    run(3, 8'h42, 8'h42, 0, 1, 0, 1, 0);    // R4 SBC with borrow-in
    run(9, 0, 8'hFF, 0, 1, 1, 1, 1);        // R6 INCSZ to zero: skip
    run(11, 0, 8'h01, 0, 0, 0, 1, 0);       // R6 DECSZ to zero: skip
    run(11, 0, 8'h05, 0, 0, 0, 1, 0);       // R6 DECSZ nonzero: no skip
    run(12, 0, 8'h80, 0, 1, 1, 0, 1);       // R7 rotate
    run(13, 0, 8'h00, 7, 0, 1, 1, 1);       // R8 set MSB, d=0 ignored
    run(14, 0, 8'hFF, 0, 0, 0, 0, 0);       // R8 clear LSB
    run(15, 0, 8'hFB, 2, 0, 0, 0, 0);       // R9 bit clear -> skip
    run(16, 0, 8'hFB, 2, 1, 0, 0, 0);       // R9 bit clear -> no skip
    run(25, 8'h12, 8'h34, 1, 1, 1, 0, 1);   // R1 unused code

    // constrained random
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 600; i++) begin
      run(int'($urandom_range(18, 0)), int'($urandom_range(255, 0)),
          int'($urandom_range(255, 0)), int'($urandom_range(7, 0)),
          int'($urandom_range(1, 0)), int'($urandom_range(1, 0)),
          int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
    end

    // R2 idle cycle: strobes drop one edge after valid falls
    valid_i = 1'b0; op_i = 5'd9; opr_i = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "idle strobes", int'({valid_o, wr_acc_o, wr_reg_o, skip_o}), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule